// File: doc/BRIEF.md
# Receive Clock-Domain Bridge with Frame Check Sequence Removal

This block carries received frame bytes from a 10/100 MAC, clocked by the MII receive clock at 2.5 or 25 MHz, into a 125 MHz host clock domain. Bytes enter through a four-entry dual-clock FIFO. The FIFO pointers are Gray-coded and pass through two-flop synchronizers.

On the host side, a state machine drains the FIFO as soon as it holds data. It turns the MAC's first-byte and last-byte markers into a host packet protocol of start-of-packet, data-valid and end-of-packet. When the strip option is selected, the state machine holds the newest four bytes of each frame in a delay line. It delivers only the bytes that come before the trailing frame check sequence, so the slow path offers the same option as a gigabit path.

The host domain runs much faster than the receive clock, so data-valid is normally low between bytes of a frame. The strip option is sampled once per frame, when the frame's first byte leaves the FIFO.

Top module: `rx_rate_bridge`

## Requirements
- R1: While either reset is high and after both are released with no input, out_valid, out_sop, out_eop and out_err are all low.
- R2: With stripping off, every byte of a frame is delivered once and in order. out_sop is high on the first byte and out_eop on the last, and out_err stays low.
- R3: With stripping on and a frame of L >= 5 bytes, exactly the first L-4 bytes are delivered in order. out_eop is high on byte L-4 and the last four bytes are never delivered.
- R4: out_sop is high only on the first delivered beat of a frame. For a 5-byte frame with stripping on, that single beat carries both out_sop and out_eop.
- R5: With stripping on, a frame of 1 to 4 bytes is delivered as one beat with out_sop, out_eop and out_err all high and out_data equal to 0.
- R6: out_valid is high only on cycles that deliver a byte or an error marker. It drops while the FIFO is empty in the middle of a frame, and out_sop/out_eop/out_err are low whenever out_valid is low.
- R7: Input bytes that arrive while no frame is open are discarded. A frame is opened by in_first, and such stray bytes include those left over from a frame cut off by reset.
- R8: With stripping off, a 1-byte frame (in_first and in_last together) is delivered as one beat with out_sop and out_eop high and out_err low.
- R9: The strip selection in force for a frame is the value of strip_en when its first byte is read. Changing strip_en later in the frame has no effect on that frame.
- R10: A frame whose first byte follows the previous frame's last byte on the very next receive clock is delivered as a separate packet with its own out_sop and out_eop.
- R11: Each FIFO pointer moves by at most one Gray-code bit per clock. The FIFO never holds more than four entries, so a long uninterrupted frame loses no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | MII receive clock (2.5 or 25 MHz) |
| wr_rst | input | 1 | Active-high asynchronous reset, receive domain |
| in_valid | input | 1 | Byte present on in_data this receive clock |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame (includes the check sequence) |
| in_data | input | 8 | Received byte |
| rd_clk | input | 1 | 125 MHz host clock |
| rd_rst | input | 1 | Active-high asynchronous reset, host domain |
| strip_en | input | 1 | 1 = remove the trailing four bytes of each frame |
| out_valid | output | 1 | A beat is present on the host outputs |
| out_sop | output | 1 | Beat is the first of a packet |
| out_eop | output | 1 | Beat is the last of a packet |
| out_err | output | 1 | Beat is an error marker for a frame too short to strip |
| out_data | output | 8 | Delivered byte |

## Verification
The assertions check, on every cycle, the host-side framing rules. A start never occurs inside an open packet, and every continuation beat lies inside one. Flags never appear without out_valid, and an error marker is always a zero-data start-and-end beat. The assertions also check that both Gray pointers step by at most one bit and that neither side sees more than four entries in flight. Only the bench scenarios can show which bytes arrive and in what order. This covers the four-byte cut and where end-of-packet lands, the error marker for short frames, the discard of stray bytes, and the per-frame capture of the strip setting. These depend on the payload and on the strip setting at frame start, which no single-cycle property sees.

// File: rtl/rx_rate_bridge.sv
module rx_rate_bridge #(
  parameter int DW        = 8,
  parameter int AW        = 2,
  parameter int CRC_BYTES = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          strip_en,
  output logic          out_valid,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_err,
  output logic [DW-1:0] out_data
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int EW    = DW + 2;
  localparam int CW    = $clog2(CRC_BYTES + 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    for (int i = 0; i < PW; i++) g2b[i] = ^(g >> i);
  endfunction

  logic [EW-1:0] mem [DEPTH];

  // ---------------- receive (write) domain ----------------
  logic [PW-1:0] wr_bin, wr_gray, rq1, rq2;
  logic [PW-1:0] rd_bin, rd_gray, wq1, wq2;
  wire  [PW-1:0] wr_bin_nx = wr_bin + 1'b1;
  wire           full = (wr_gray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  wire           push = in_valid && !full;

  always_ff @(posedge wr_clk or posedge wr_rst)
    if (wr_rst) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (push) begin
      wr_bin  <= wr_bin_nx;
      wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
    end

  always_ff @(posedge wr_clk)
    if (push) mem[wr_bin[AW-1:0]] <= {in_first, in_last, in_data};

  always_ff @(posedge wr_clk or posedge wr_rst)
    if (wr_rst) {rq2, rq1} <= '0;
    else        {rq2, rq1} <= {rq1, rd_gray};

  // ---------------- host (read) domain ----------------
  wire [PW-1:0] rd_bin_nx = rd_bin + 1'b1;
  wire          empty = (rd_gray == wq2);
  wire          pop   = !empty;
  wire [EW-1:0] entry = mem[rd_bin[AW-1:0]];
  wire          e_first = entry[DW+1];
  wire          e_last  = entry[DW];
  wire [DW-1:0] e_data  = entry[DW-1:0];

  always_ff @(posedge rd_clk or posedge rd_rst)
    if (rd_rst) {wq2, wq1} <= '0;
    else        {wq2, wq1} <= {wq1, wr_gray};

  always_ff @(posedge rd_clk or posedge rd_rst)
    if (rd_rst) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (pop) begin
      rd_bin  <= rd_bin_nx;
      rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
    end

  logic          in_frame, frame_strip, sop_pend;
  logic [CW-1:0] cnt;
  logic [DW-1:0] line [CRC_BYTES];

  always_ff @(posedge rd_clk or posedge rd_rst)
    if (rd_rst) begin
      in_frame    <= 1'b0;
      frame_strip <= 1'b0;
      sop_pend    <= 1'b0;
      cnt         <= '0;
      for (int i = 0; i < CRC_BYTES; i++) line[i] <= '0;
      out_valid   <= 1'b0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_err     <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= 1'b0;
      if (pop) begin
        if (e_first) begin
          in_frame    <= !e_last;
          frame_strip <= strip_en;
          sop_pend    <= 1'b0;
          cnt         <= '0;
          if (!strip_en) begin
            out_valid <= 1'b1;
            out_sop   <= 1'b1;
            out_eop   <= e_last;
            out_data  <= e_data;
          end else if (e_last) begin
            out_valid <= 1'b1;
            out_sop   <= 1'b1;
            out_eop   <= 1'b1;
            out_err   <= 1'b1;
            out_data  <= '0;
          end else begin
            line[0]  <= e_data;
            cnt      <= CW'(1);
            sop_pend <= 1'b1;
          end
        end else if (in_frame) begin
          if (e_last) in_frame <= 1'b0;
          if (!frame_strip) begin
            out_valid <= 1'b1;
            out_eop   <= e_last;
            out_data  <= e_data;
          end else if (cnt == CW'(CRC_BYTES)) begin
            out_valid <= 1'b1;
            out_sop   <= sop_pend;
            out_eop   <= e_last;
            out_data  <= line[0];
            sop_pend  <= 1'b0;
            for (int i = 0; i < CRC_BYTES - 1; i++) line[i] <= line[i+1];
            line[CRC_BYTES-1] <= e_data;
          end else if (e_last) begin
            out_valid <= 1'b1;
            out_sop   <= 1'b1;
            out_eop   <= 1'b1;
            out_err   <= 1'b1;
            out_data  <= '0;
            sop_pend  <= 1'b0;
          end else begin
            for (int i = 0; i < CRC_BYTES; i++)
              if (cnt == CW'(i)) line[i] <= e_data;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end

  // ---------------- assertions ----------------
  logic pkt_open;
  always_ff @(posedge rd_clk or posedge rd_rst)
    if (rd_rst)         pkt_open <= 1'b0;
    else if (out_valid) pkt_open <= !out_eop;

  a_r4_sop_outside_packet: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_valid && out_sop |-> !pkt_open);
  a_r2_continuation_inside_packet: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_valid && !out_sop |-> pkt_open);
  a_r5_err_marker_shape: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_err |-> out_valid && out_sop && out_eop && out_data == '0);
  a_r6_flags_need_valid: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !out_valid |-> !(out_sop || out_eop || out_err));
  a_r11_wr_gray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  a_r11_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
  a_r11_wr_occupancy: assert property (@(posedge wr_clk) disable iff (wr_rst)
    PW'(wr_bin - g2b(rq2)) <= PW'(DEPTH));
  a_r11_rd_occupancy: assert property (@(posedge rd_clk) disable iff (rd_rst)
    PW'(g2b(wq2) - rd_bin) <= PW'(DEPTH));
endmodule

// File: tb/test_rx_rate_bridge.sv
module test_rx_rate_bridge;
  localparam int RD_PERIOD = 8;
  localparam int WR_PERIOD = 40;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic strip_en = 0;
  logic out_valid, out_sop, out_eop, out_err;
  logic [7:0] out_data;

  always #(RD_PERIOD/2) rd_clk = ~rd_clk;
  always #(WR_PERIOD/2) wr_clk = ~wr_clk;

  rx_rate_bridge i_rx_rate_bridge (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .strip_en(strip_en), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err), .out_data(out_data));

  typedef struct packed {logic sop; logic eop; logic err; logic [7:0] d;} beat_t;
  beat_t exp_q[$];
  string req_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: compare every host clock
  always @(negedge rd_clk) begin
    if (!rd_rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0)
          check(0, "R6", "unexpected beat {sop,eop,err,data}",
                {21'd0, out_sop, out_eop, out_err, out_data}, 0);
        else begin
          beat_t b;
          string r;
          b = exp_q.pop_front();
          r = req_q.pop_front();
          check({out_sop, out_eop, out_err, out_data} == b, r, "beat {sop,eop,err,data}",
                {21'd0, out_sop, out_eop, out_err, out_data}, {21'd0, b});
        end
      end else if (out_sop || out_eop || out_err)
        check(0, "R6", "flags without valid", {29'd0, out_sop, out_eop, out_err}, 0);
    end
  end

  task automatic expect_frame(input int len, input int base, input bit strip, input string req);
    if (!strip) begin
      for (int i = 0; i < len; i++) begin
        exp_q.push_back({i == 0, i == len - 1, 1'b0, 8'(base + i)});
        req_q.push_back(req);
      end
    end else if (len <= 4) begin
      exp_q.push_back({1'b1, 1'b1, 1'b1, 8'h00});
      req_q.push_back(req);
    end else begin
      for (int i = 0; i < len - 4; i++) begin
        exp_q.push_back({i == 0, i == len - 5, 1'b0, 8'(base + i)});
        req_q.push_back(req);
      end
    end
  endtask

  // drives bytes; leaves the last byte on the bus for the caller to clear
  task automatic send_frame(input int len, input int base, input int gap,
                            input int flip_at, input string req);
    expect_frame(len, base, strip_en, req);
    for (int i = 0; i < len; i++) begin
      @(negedge wr_clk);
      in_valid = 1; in_first = (i == 0); in_last = (i == len - 1);
      in_data = 8'(base + i);
      if (i == flip_at) strip_en = ~strip_en;
      if (gap > 0 && i != len - 1) begin
        @(negedge wr_clk);
        in_valid = 0;
        repeat (gap - 1) @(negedge wr_clk);
      end
    end
  endtask

  task automatic send_orphans(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      in_valid = 1; in_first = 0; in_last = (i == n - 1); in_data = 8'(base + i);
    end
  endtask

  task automatic idle(input int n);
    @(negedge wr_clk);
    in_valid = 0; in_first = 0; in_last = 0;
    repeat (n) @(negedge wr_clk);
  endtask

  initial begin
    #(RD_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge wr_clk);
    check({out_valid, out_sop, out_eop, out_err} == 0, "R1", "outputs in reset",
          {28'd0, out_valid, out_sop, out_eop, out_err}, 0);
    wr_rst = 0; rd_rst = 0;
    repeat (3) @(negedge wr_clk);
    check({out_valid, out_sop, out_eop, out_err} == 0, "R1", "outputs after reset",
          {28'd0, out_valid, out_sop, out_eop, out_err}, 0);

    strip_en = 0;
    send_frame(8, 8'h10, 0, -1, "R2");  idle(4);
    send_frame(6, 8'h30, 3, -1, "R6");  idle(4);
    send_frame(1, 8'h55, 0, -1, "R8");  idle(4);

    strip_en = 1;
    send_frame(10, 8'h60, 0, -1, "R3"); idle(4);
    send_frame(5, 8'h80, 1, -1, "R4");  idle(4);
    send_frame(4, 8'h90, 0, -1, "R5");  idle(4);
    send_frame(1, 8'h98, 0, -1, "R5");  idle(4);
    send_frame(3, 8'h9a, 2, -1, "R5");  idle(4);

    send_orphans(3, 8'hc0);             idle(4);
    send_frame(6, 8'ha0, 0, -1, "R7");  idle(4);

    send_frame(7, 8'hb0, 0, -1, "R10");
    send_frame(6, 8'hd0, 0, -1, "R10"); idle(4);
    strip_en = 0;
    send_frame(3, 8'he0, 0, -1, "R10");
    send_frame(4, 8'he8, 0, -1, "R10"); idle(4);

    strip_en = 1;
    send_frame(9, 8'h20, 0, 3, "R9");   idle(4);
    check(strip_en == 0, "R9", "strip toggled", {31'd0, strip_en}, 0);
    send_frame(7, 8'h40, 0, 3, "R9");   idle(4);
    strip_en = 0;
    send_frame(40, 8'h00, 0, -1, "R11"); idle(6);

    check(exp_q.size() == 0, "R2", "undelivered beats", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule